// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that works through a linked list of descriptors held in memory. A pulse on the start input hands it a pointer to the first descriptor. The channel reads that descriptor's four words through a single memory port. It then copies data from the source region to the target region in bursts. Each burst is read in full into an internal 32-byte buffer and then written out in full. The command word of the loaded descriptor sets the element width, the burst size, which addresses step, and whether the transfer is paced by a request line.

When a descriptor finishes, the channel either fetches the next descriptor through the link pointer or halts. It halts when the link word carries a stop flag, when descriptor fetching is disabled, or when stop-on-end-of-receive is configured. A link word may also ask for a branch: the next fetch is then taken 32 bytes past the aligned pointer whenever the compare-status input is high. On a request-paced transfer, a request that has dropped after a burst counts as an end of receive. That event can halt the channel, make it jump to the next descriptor, or leave it waiting for the request to come back.

Status flags stay set until the next start: run, stop, end, start and end-of-receive. The loaded link, source, target and command words are visible on output ports. The low 13 bits of the command output always show the length still to transfer.

Top module: `dma_chain_engine`

## Requirements
- R1: A fetch issues four 4-byte reads at consecutive word addresses, starting at the pointer with its low 4 bits cleared. The words load, in order, the link, source, target and command registers.
- R2: If bit 1 of the link pointer is 1 and cmp_status_i is high when the fetch begins, the fetch starts at the aligned pointer plus 32. The pointer given on start_ptr_i is fetched the same way.
- R3: Command bits 12:0 give the length in bytes. Bits 15:14 select the element width: code 1 is 1 byte, code 2 is 2 bytes, code 3 is 4 bytes, and code 0 is treated as 1 byte. The burst is 4 << bits 17:16 bytes. Each burst moves the smaller of the burst size and the remaining length, reading all of its elements before writing any. Elements sit in the low byte lanes of the data buses.
- R4: Command bit 31 makes the source address advance by the element width per element, and bit 30 does the same for the target. With a bit clear, that address stays fixed.
- R5: Command bit 29 (source paced) or bit 28 (target paced) makes the channel wait for dreq_i high before each burst, with no memory access while it waits. When the descriptor loads, each paced address has its low 2 bits cleared.
- R6: On a paced transfer, if dreq_i is low after a burst and length remains, eor_o is set. Then, with eor_stop_i high, the channel halts. Otherwise, with eor_jump_i high and no_fetch_i low, it fetches the next descriptor. Otherwise it waits for dreq_i and resumes the same descriptor.
- R7: When the length reaches zero, end_o is set if command bit 21 is 1. The channel halts (stop_o set, run_o cleared) if no_fetch_i is high, link bit 0 is 1, or eor_stop_i is high. Otherwise it fetches the descriptor at the link pointer.
- R8: If command bit 22 is 1, start_st_o is set when the descriptor loads.
- R9: After each burst, the remaining length is written back into command bits 12:0, and bits 31:13 are left unchanged.
- R10: A memory request holds its address, write enable and write data stable until mem_ack_i, and only one access is outstanding at a time.
- R11: start_i is ignored while run_o is high. A start accepted while idle clears all status flags.
- R12: After reset the channel is idle, with no memory request and all status flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| start_ptr_i | input | ADDR_W | Pointer to the first descriptor |
| cmp_status_i | input | 1 | Compare status used for branch fetches |
| no_fetch_i | input | 1 | Disable fetching after the first descriptor |
| eor_stop_i | input | 1 | Halt on end of receive and at completion |
| eor_jump_i | input | 1 | Jump to the next descriptor on end of receive |
| dreq_i | input | 1 | Flow-control request |
| mem_req_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_bytes_o | output | 3 | Access size in bytes (1, 2 or 4) |
| mem_wdata_o | output | DATA_W | Write data, low lanes used |
| mem_ack_i | input | 1 | Access accepted or completed |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_ack_i |
| run_o | output | 1 | Channel active |
| stop_o | output | 1 | Stop status |
| end_o | output | 1 | End status |
| start_st_o | output | 1 | Start status |
| eor_o | output | 1 | End-of-receive status |
| cur_next_o | output | ADDR_W | Loaded link word |
| cur_src_o | output | ADDR_W | Current source address |
| cur_dst_o | output | ADDR_W | Current target address |
| cur_cmd_o | output | 32 | Command word with the remaining length |

## Verification
The bench memory answers a request at the falling edge after it sees it, so each access finishes on the next rising edge. A write is checked against the scoreboard queue in that same half cycle. Status flags and the address registers change on the rising edge that completes the last write of a burst, or on the edge after it. The bench therefore reads them only at a falling edge once run_o has dropped, or after a settled wait of many cycles. The pacing checks drop dreq_i in the half cycle when the deciding write is acknowledged, so the channel sees the low request on the edge where it makes its decision.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
   localparam int LEN_W = 13;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_LOAD, S_CHECK, S_READ, S_WRITE, S_POST
   } chan_state_e;

   typedef struct packed {
      logic [LEN_W-1:0] len;
      logic [2:0]       width;
      logic [5:0]       burst;
      logic             inc_src;
      logic             inc_dst;
      logic             flow;
      logic             end_ie;
      logic             start_ie;
   } cmd_view_t;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
   import dma_chain_pkg::*;
(
   input  logic [31:0] cmd_i,
   output cmd_view_t   view_o
);
   logic unused_cmd_bits;
   assign unused_cmd_bits = ^{cmd_i[27:23], cmd_i[20:18]};

   always_comb begin
      view_o.len = cmd_i[LEN_W-1:0];
      case (cmd_i[15:14])
         2'd2:    view_o.width = 3'd2;
         2'd3:    view_o.width = 3'd4;
         default: view_o.width = 3'd1;
      endcase
      view_o.burst    = 6'(6'd4 << cmd_i[17:16]);
      view_o.inc_src  = cmd_i[31];
      view_o.inc_dst  = cmd_i[30];
      view_o.flow     = cmd_i[29] | cmd_i[28];
      view_o.end_ie   = cmd_i[21];
      view_o.start_ie = cmd_i[22];
   end
endmodule

// File: rtl/dma_desc_addr.sv
module dma_desc_addr #(
   parameter int ADDR_W = 32,
   parameter int BRANCH_STEP = 32
) (
   input  logic [ADDR_W-1:0] ptr_i,
   input  logic              cmp_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic unused_ptr_bits;
   assign unused_ptr_bits = ^{ptr_i[3:2], ptr_i[0]};

   logic [ADDR_W-1:0] aligned;
   assign aligned = {ptr_i[ADDR_W-1:4], 4'b0000};
   assign addr_o  = aligned + ((ptr_i[1] && cmp_i) ? ADDR_W'(BRANCH_STEP) : '0);
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
   parameter int BUF_BYTES = 32,
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8,
   localparam int LANE_W = $clog2(LANES),
   localparam int OFF_W = $clog2(BUF_BYTES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [2:0]        wr_bytes,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [OFF_W-1:0]  rd_off,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [OFF_W-1:0] LIMIT = OFF_W'(BUF_BYTES);

   logic [8*BUF_BYTES-1:0] flat;
   logic [OFF_W-1:0]       wr_end;
   assign wr_end = wr_off + OFF_W'(wr_bytes);

   for (genvar i = 0; i < BUF_BYTES; i++) begin : g_byte
      logic [7:0]       q;
      logic [OFF_W-1:0] lane;
      logic             hit;
      assign lane = OFF_W'(i) - wr_off;
      assign hit  = wr_en && (OFF_W'(i) >= wr_off) && (OFF_W'(i) < wr_end);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (hit) q <= wr_data[{lane[LANE_W-1:0], 3'b000} +: 8];
      end
      assign flat[8*i +: 8] = q;
   end

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [OFF_W-1:0] idx;
      assign idx = rd_off + OFF_W'(j);
      assign rd_data[8*j +: 8] = (idx < LIMIT) ? flat[{idx, 3'b000} +: 8] : 8'h00;
   end

   p_buf_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_end <= LIMIT));
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
   import dma_chain_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int BUF_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] start_ptr_i,
   input  logic              cmp_status_i,
   input  logic              no_fetch_i,
   input  logic              eor_stop_i,
   input  logic              eor_jump_i,
   input  logic              dreq_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [2:0]        mem_bytes_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              run_o,
   output logic              stop_o,
   output logic              end_o,
   output logic              start_st_o,
   output logic              eor_o,
   output logic [ADDR_W-1:0] cur_next_o,
   output logic [ADDR_W-1:0] cur_src_o,
   output logic [ADDR_W-1:0] cur_dst_o,
   output logic [31:0]       cur_cmd_o
);
   localparam int OFF_W = $clog2(BUF_BYTES) + 1;

   if (ADDR_W != 32 || DATA_W != 32) begin : g_bad_width
      $error("dma_chain_engine: descriptor words require 32-bit address and data");
   end
   if (BUF_BYTES < 32) begin : g_bad_buf
      $error("dma_chain_engine: buffer must hold the largest burst");
   end

   chan_state_e       state_q;
   logic [1:0]        fidx_q;
   logic [ADDR_W-1:0] fetch_q, next_q, src_q, dst_q;
   logic [31:0]       cmd_q;
   logic [OFF_W-1:0]  off_q, blen_q;
   logic              stop_q, end_q, sst_q, eor_q;

   cmd_view_t         f;
   logic [ADDR_W-1:0] ptr_sel, fetch_d;
   logic [OFF_W-1:0]  nxt_off, blen_d;
   logic              last_elem, halt_now;

   dma_cmd_decode u_dec (.cmd_i(cmd_q), .view_o(f));

   assign ptr_sel = (state_q == S_IDLE) ? start_ptr_i : next_q;
   dma_desc_addr #(.ADDR_W(ADDR_W)) u_daddr (
      .ptr_i(ptr_sel), .cmp_i(cmp_status_i), .addr_o(fetch_d));

   assign nxt_off   = off_q + OFF_W'(f.width);
   assign last_elem = nxt_off >= blen_q;
   assign blen_d    = (f.len < LEN_W'(f.burst)) ? OFF_W'(f.len) : OFF_W'(f.burst);
   assign halt_now  = no_fetch_i || next_q[0] || eor_stop_i;

   logic [DATA_W-1:0] buf_rd;
   logic              buf_wr;
   assign buf_wr = (state_q == S_READ) && mem_ack_i;

   dma_burst_buf #(.BUF_BYTES(BUF_BYTES), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(buf_wr), .wr_off(off_q), .wr_bytes(f.width), .wr_data(mem_rdata_i),
      .rd_off(off_q), .rd_data(buf_rd));

   always_comb begin
      mem_req_o   = 1'b0;
      mem_we_o    = 1'b0;
      mem_addr_o  = '0;
      mem_bytes_o = 3'd4;
      mem_wdata_o = buf_rd;
      case (state_q)
         S_FETCH: begin
            mem_req_o  = 1'b1;
            mem_addr_o = fetch_q + ADDR_W'({fidx_q, 2'b00});
         end
         S_READ: begin
            mem_req_o   = 1'b1;
            mem_addr_o  = src_q;
            mem_bytes_o = f.width;
         end
         S_WRITE: begin
            mem_req_o   = 1'b1;
            mem_we_o    = 1'b1;
            mem_addr_o  = dst_q;
            mem_bytes_o = f.width;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         fidx_q  <= '0;
         fetch_q <= '0;
         next_q  <= '0;
         src_q   <= '0;
         dst_q   <= '0;
         cmd_q   <= '0;
         off_q   <= '0;
         blen_q  <= '0;
         stop_q  <= 1'b0;
         end_q   <= 1'b0;
         sst_q   <= 1'b0;
         eor_q   <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: if (start_i) begin
               next_q  <= start_ptr_i;
               fetch_q <= fetch_d;
               fidx_q  <= '0;
               stop_q  <= 1'b0;
               end_q   <= 1'b0;
               sst_q   <= 1'b0;
               eor_q   <= 1'b0;
               state_q <= S_FETCH;
            end
            S_FETCH: if (mem_ack_i) begin
               case (fidx_q)
                  2'd0: next_q <= mem_rdata_i;
                  2'd1: src_q  <= mem_rdata_i;
                  2'd2: dst_q  <= mem_rdata_i;
                  default: cmd_q <= mem_rdata_i;
               endcase
               fidx_q <= fidx_q + 2'd1;
               if (fidx_q == 2'd3) state_q <= S_LOAD;
            end
            S_LOAD: begin
               if (cmd_q[29]) src_q[1:0] <= 2'b00;
               if (cmd_q[28]) dst_q[1:0] <= 2'b00;
               if (f.start_ie) sst_q <= 1'b1;
               state_q <= S_CHECK;
            end
            S_CHECK: begin
               if (f.len == '0) state_q <= S_POST;
               else if (!f.flow || dreq_i) begin
                  blen_q  <= blen_d;
                  off_q   <= '0;
                  state_q <= S_READ;
               end
            end
            S_READ: if (mem_ack_i) begin
               if (f.inc_src) src_q <= src_q + ADDR_W'(f.width);
               if (last_elem) begin
                  off_q   <= '0;
                  state_q <= S_WRITE;
               end else off_q <= nxt_off;
            end
            S_WRITE: if (mem_ack_i) begin
               if (f.inc_dst) dst_q <= dst_q + ADDR_W'(f.width);
               if (last_elem) begin
                  cmd_q[LEN_W-1:0] <= f.len - LEN_W'(blen_q);
                  state_q <= S_POST;
               end else off_q <= nxt_off;
            end
            S_POST: begin
               if (f.len == '0) begin
                  if (f.end_ie) end_q <= 1'b1;
                  if (halt_now) begin
                     stop_q  <= 1'b1;
                     state_q <= S_IDLE;
                  end else begin
                     fetch_q <= fetch_d;
                     fidx_q  <= '0;
                     state_q <= S_FETCH;
                  end
               end else if (f.flow && !dreq_i) begin
                  eor_q <= 1'b1;
                  if (eor_stop_i) begin
                     stop_q  <= 1'b1;
                     state_q <= S_IDLE;
                  end else if (eor_jump_i && !no_fetch_i) begin
                     fetch_q <= fetch_d;
                     fidx_q  <= '0;
                     state_q <= S_FETCH;
                  end else state_q <= S_CHECK;
               end else state_q <= S_CHECK;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign run_o      = (state_q != S_IDLE);
   assign stop_o     = stop_q;
   assign end_o      = end_q;
   assign start_st_o = sst_q;
   assign eor_o      = eor_q;
   assign cur_next_o = next_q;
   assign cur_src_o  = src_q;
   assign cur_dst_o  = dst_q;
   assign cur_cmd_o  = cmd_q;

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

   p_fetch_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_FETCH) |-> (mem_addr_o[1:0] == 2'b00 && !mem_we_o));

   p_flow_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_CHECK && f.flow && !dreq_i && f.len != '0) |=> !mem_req_o);

   p_stop_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_q) |-> !run_o);

   p_len_shrinks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WRITE && mem_ack_i && last_elem) |=>
         (cmd_q[LEN_W-1:0] < $past(cmd_q[LEN_W-1:0]) && $stable(cmd_q[31:LEN_W])));

   p_eor_paced_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eor_q) |-> $past(f.flow && !dreq_i));

   p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_q != S_IDLE && state_q != S_FETCH) |=> $stable(next_q));
endmodule

// File: tb/dma_chain_engine_bench.sv
`timescale 1ns/1ps
module dma_chain_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] start_ptr = '0;
   logic        cmp = 1'b0, nofetch = 1'b0, eorstop = 1'b0, eorjump = 1'b0, dreq = 1'b0;
   logic        mem_req_o, mem_we_o, mem_ack = 1'b0;
   logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata = '0;
   logic [2:0]  mem_bytes_o;
   logic        run_o, stop_o, end_o, start_st_o, eor_o;
   logic [31:0] cur_next_o, cur_src_o, cur_dst_o, cur_cmd_o;

   always #2 clk = ~clk;

   dma_chain_engine u_dma_chain_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start), .start_ptr_i(start_ptr),
      .cmp_status_i(cmp), .no_fetch_i(nofetch), .eor_stop_i(eorstop),
      .eor_jump_i(eorjump), .dreq_i(dreq),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_bytes_o(mem_bytes_o), .mem_wdata_o(mem_wdata_o),
      .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
      .run_o(run_o), .stop_o(stop_o), .end_o(end_o), .start_st_o(start_st_o),
      .eor_o(eor_o), .cur_next_o(cur_next_o), .cur_src_o(cur_src_o),
      .cur_dst_o(cur_dst_o), .cur_cmd_o(cur_cmd_o));

   typedef struct { logic [31:0] addr; logic [31:0] data; int bytes; } wr_item_t;

   logic [7:0] mem [int unsigned];
   wr_item_t   exp_q[$];
   int vectors = 0, fails = 0, wcount = 0, drop_at = -1;

   function automatic logic [7:0] rdb(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 8'h00;
   endfunction

   function automatic logic [31:0] rdw(input logic [31:0] a);
      return {rdb(a + 3), rdb(a + 2), rdb(a + 1), rdb(a)};
   endfunction

   function automatic logic [31:0] lane_mask(input int b);
      return (b >= 4) ? 32'hffff_ffff : ((32'h1 << (8 * b)) - 1);
   endfunction

   task automatic put32(input logic [31:0] a, input logic [31:0] v);
      for (int b = 0; b < 4; b++) mem[a + b] = v[8*b +: 8];
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] nx,
                           input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
      put32(a, nx); put32(a + 4, s); put32(a + 8, d); put32(a + 12, c);
   endtask

   task automatic fill(input logic [31:0] a, input int words, input logic [31:0] seed);
      for (int k = 0; k < words; k++) put32(a + 4 * k, seed ^ (32'h0101_0101 * k) ^ (k << 20));
   endtask

   task automatic expect_copy(input logic [31:0] s, input logic [31:0] d, input int nbytes,
                              input int w, input bit inc_s, input bit inc_d);
      for (int k = 0; k < nbytes; k += w) begin
         wr_item_t it;
         it.addr  = d + (inc_d ? k : 0);
         it.bytes = w;
         it.data  = rdw(s + (inc_s ? k : 0)) & lane_mask(w);
         exp_q.push_back(it);
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
      vectors++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, expv);
      end
   endtask

   // memory model and write scoreboard monitor
   always @(negedge clk) begin
      if (!rst_n) mem_ack = 1'b0;
      else if (mem_ack) mem_ack = 1'b0;
      else if (mem_req_o) begin
         if (mem_we_o) begin
            for (int b = 0; b < int'(mem_bytes_o); b++) mem[mem_addr_o + b] = mem_wdata_o[8*b +: 8];
            wcount++;
            vectors++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R3/R4 unexpected write actual addr=%h data=%h expected none",
                        mem_addr_o, mem_wdata_o);
            end else begin
               wr_item_t e;
               e = exp_q.pop_front();
               if (mem_addr_o !== e.addr || int'(mem_bytes_o) != e.bytes ||
                   (mem_wdata_o & lane_mask(e.bytes)) !== e.data) begin
                  fails++;
                  $display("FAIL R3/R4 write actual addr=%h size=%0d data=%h expected addr=%h size=%0d data=%h",
                           mem_addr_o, mem_bytes_o, mem_wdata_o & lane_mask(e.bytes),
                           e.addr, e.bytes, e.data);
               end
            end
            if (wcount == drop_at) dreq = 1'b0;
         end else mem_rdata = rdw(mem_addr_o);
         mem_ack = 1'b1;
      end
   end

   task automatic kick(input logic [31:0] p);
      @(negedge clk);
      start_ptr = p;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4000 && run_o; i++) @(negedge clk);
   endtask

   task automatic setup(input bit c, input bit nf, input bit es, input bit ej, input bit rq, input int drop);
      @(negedge clk);
      cmp = c; nofetch = nf; eorstop = es; eorjump = ej; dreq = rq;
      wcount = 0; drop_at = drop;
   endtask

   localparam logic [31:0] INC_S = 32'h8000_0000, INC_D = 32'h4000_0000;
   localparam logic [31:0] FLOW_S = 32'h2000_0000, FLOW_D = 32'h1000_0000;
   localparam logic [31:0] START_IE = 32'h0040_0000, END_IE = 32'h0020_0000;

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 run after reset", {31'b0, run_o}, 32'd0);
      chk("R12 stop after reset", {31'b0, stop_o}, 32'd0);
      chk("R12 request after reset", {31'b0, mem_req_o}, 32'd0);
      rst_n = 1'b1;

      // R1 R3 R4 R8 R7 R9: plain 4-byte copy, 8-byte bursts, unaligned pointer
      fill(32'h2000, 8, 32'hA5C3_1000);
      put_desc(32'h1000, 32'h1, 32'h2000, 32'h3000,
               INC_S | INC_D | START_IE | END_IE | (3 << 14) | (1 << 16) | 20);
      setup(0, 0, 0, 0, 0, -1);
      expect_copy(32'h2000, 32'h3000, 20, 4, 1, 1);
      kick(32'h1008);
      wait_idle();
      chk("R7 stop on link stop bit", {31'b0, stop_o}, 32'd1);
      chk("R7 end status", {31'b0, end_o}, 32'd1);
      chk("R8 start status", {31'b0, start_st_o}, 32'd1);
      chk("R1 source final", cur_src_o, 32'h2014);
      chk("R4 target final", cur_dst_o, 32'h3014);
      chk("R9 command written back",
          cur_cmd_o, INC_S | INC_D | START_IE | END_IE | (3 << 14) | (1 << 16));
      chk("R3 writes pending", exp_q.size(), 0);

      // R2 branch fetch, R4 fixed source, R7 chaining with no end status
      fill(32'h2100, 2, 32'h1357_9BDF);
      fill(32'h2200, 2, 32'h2468_ACE0);
      put_desc(32'h1100, 32'h1202, 32'h2100, 32'h3100, INC_D | (2 << 14) | 6);
      put_desc(32'h1200, 32'h1, 32'h9000, 32'h9100, INC_S | INC_D | (1 << 14) | 4);
      put_desc(32'h1220, 32'h1, 32'h2200, 32'h3200, INC_S | INC_D | (1 << 14) | (2 << 16) | 3);
      setup(1, 0, 0, 0, 0, -1);
      expect_copy(32'h2100, 32'h3100, 6, 2, 0, 1);
      expect_copy(32'h2200, 32'h3200, 3, 1, 1, 1);
      kick(32'h1100);
      wait_idle();
      chk("R2 branch target source", cur_src_o, 32'h2203);
      chk("R2 branch target dest", cur_dst_o, 32'h3203);
      chk("R7 end stays low", {31'b0, end_o}, 32'd0);
      chk("R8 start stays low", {31'b0, start_st_o}, 32'd0);
      chk("R2 writes pending", exp_q.size(), 0);

      // R5 pacing wait and source alignment, R6 stop on end of receive
      fill(32'h4000, 4, 32'h0F1E_2D3C);
      put_desc(32'h1300, 32'h1400, 32'h4003, 32'h5000,
               FLOW_S | INC_S | INC_D | (3 << 14) | (1 << 16) | 16);
      setup(0, 0, 1, 0, 0, 2);
      kick(32'h1300);
      repeat (40) @(negedge clk);
      chk("R5 no access while request low", {31'b0, mem_req_o}, 32'd0);
      chk("R5 source aligned", cur_src_o, 32'h4000);
      chk("R5 still running", {31'b0, run_o}, 32'd1);
      expect_copy(32'h4000, 32'h5000, 8, 4, 1, 1);
      dreq = 1'b1;
      wait_idle();
      chk("R6 eor status", {31'b0, eor_o}, 32'd1);
      chk("R6 eor stop", {31'b0, stop_o}, 32'd1);
      chk("R9 remaining after eor", cur_cmd_o & 32'h1fff, 32'd8);
      chk("R6 source after one burst", cur_src_o, 32'h4008);

      // R6 jump on end of receive, R5 target alignment
      fill(32'h4100, 6, 32'h7777_1111);
      fill(32'h2300, 2, 32'h5A5A_0000);
      put_desc(32'h1500, 32'h1600, 32'h4100, 32'h5102,
               FLOW_D | INC_S | INC_D | (3 << 14) | (1 << 16) | 24);
      put_desc(32'h1600, 32'h1, 32'h2300, 32'h3300,
               END_IE | INC_S | INC_D | (3 << 14) | (1 << 16) | 8);
      setup(0, 0, 0, 1, 1, 2);
      expect_copy(32'h4100, 32'h5100, 8, 4, 1, 1);
      expect_copy(32'h2300, 32'h3300, 8, 4, 1, 1);
      kick(32'h1500);
      wait_idle();
      chk("R6 eor before jump", {31'b0, eor_o}, 32'd1);
      chk("R7 end after jumped descriptor", {31'b0, end_o}, 32'd1);
      chk("R6 jumped source", cur_src_o, 32'h2308);
      chk("R6 writes pending", exp_q.size(), 0);

      // R6 wait-and-resume, R11 start ignored while running
      fill(32'h4200, 4, 32'h3C3C_9090);
      put_desc(32'h1700, 32'h1, 32'h4200, 32'h5200,
               FLOW_S | INC_S | INC_D | (3 << 14) | (1 << 16) | 16);
      setup(0, 0, 0, 0, 1, 2);
      expect_copy(32'h4200, 32'h5200, 16, 4, 1, 1);
      kick(32'h1700);
      for (int i = 0; i < 2000 && !eor_o; i++) @(negedge clk);
      repeat (20) @(negedge clk);
      chk("R6 waits running", {31'b0, run_o}, 32'd1);
      chk("R6 no access while waiting", {31'b0, mem_req_o}, 32'd0);
      chk("R9 remaining while waiting", cur_cmd_o & 32'h1fff, 32'd8);
      chk("R6 no stop while waiting", {31'b0, stop_o}, 32'd0);
      kick(32'h1000);
      repeat (5) @(negedge clk);
      chk("R11 start ignored source", cur_src_o, 32'h4208);
      chk("R11 start ignored link", cur_next_o, 32'h1);
      drop_at = -1;
      dreq = 1'b1;
      wait_idle();
      chk("R6 resumed to completion", cur_src_o, 32'h4210);
      chk("R6 eor sticky", {31'b0, eor_o}, 32'd1);
      chk("R6 writes pending", exp_q.size(), 0);

      // R7 no-fetch halts without link stop, R11 status cleared on start
      fill(32'h2400, 2, 32'hDEAD_0000);
      put_desc(32'h1800, 32'h1900, 32'h2400, 32'h3400,
               INC_S | INC_D | (3 << 14) | (3 << 16) | 8);
      put_desc(32'h1900, 32'h1, 32'h9200, 32'h9300, INC_S | INC_D | (1 << 14) | 4);
      setup(0, 1, 0, 0, 0, -1);
      expect_copy(32'h2400, 32'h3400, 8, 4, 1, 1);
      kick(32'h1800);
      wait_idle();
      chk("R7 no-fetch stop", {31'b0, stop_o}, 32'd1);
      chk("R7 no-fetch link kept", cur_next_o, 32'h1900);
      chk("R7 no-fetch source", cur_src_o, 32'h2408);
      chk("R11 eor cleared by start", {31'b0, eor_o}, 32'd0);
      chk("R7 writes pending", exp_q.size(), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule